// File: doc/BRIEF.md
# Banked GPIO Simple I/O Controller

This block serves 64 general-purpose pins split into eight banks of eight. Software sets up the pins through a register index/data port that sits in the GPIO device space of the configuration interface. Each pin can be handed to this block or left to its alternate function, set to drive or to sense, and for the first five banks made to invert its sensed level. Bank data registers then appear on a separate byte-wide I/O bus. They occupy eight consecutive addresses that start at a relocatable base. Pad buffers are modelled as an output-enable vector and an output-value vector, and the sensed levels come in on a 64-bit input vector.

The I/O decoder is a two-state machine, `DEC_OFF` and `DEC_ON`. It sits in `DEC_OFF` after reset and takes the `off_to_on` transition on the clock after the base register becomes nonzero. It takes `on_to_off` on the clock after the base returns to zero, and otherwise stays where it is. Data reads are combinational. Every register write takes effect on the rising clock edge that samples its strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Reset clears every output-enable bit, output latch bit, simple-I/O select bit, inversion bit and the base address, so `pad_oe` and `pad_out` are all zero after reset.
- R2: Pin n belongs to bank n/8 at bit n%8. Bank g's data register answers at I/O address base+g, for g from 0 to 7, with the 16-bit sum allowed to run past 0xFFFF without wrapping. Reads at any other address return 0x00, and writes at any other address change nothing.
- R3: While the base is zero the decoder is in `DEC_OFF`: reads return 0x00 and writes leave every latch unchanged. The decoder moves to `DEC_ON` one clock after the base becomes nonzero, and back to `DEC_OFF` one clock after it returns to zero.
- R4: The base address is written and read as two bytes: the high byte at configuration index 0x62 and the low byte at index 0x63.
- R5: Simple-I/O select registers for banks 0 to 4 sit at indices 0xC0 to 0xC4 and read back as written, with 1 handing the pin to this block. Banks 5 to 7 are always simple I/O.
- R6: Output-enable registers for banks 0 to 7 sit at indices 0xC8 to 0xCF and read back as written. A 1 makes the pin drive and a 0 makes it an input.
- R7: Inversion registers for banks 0 to 4 sit at indices 0xB0 to 0xB4 and read back as written. A 1 inverts the sensed level that an input pin returns on a data read.
- R8: A data write loads all eight latch bits of the bank, whatever the pins' direction and select settings.
- R9: `pad_oe[n]` is 1 only when pin n is simple I/O and its output enable is 1, and `pad_out[n]` equals its latch bit when `pad_oe[n]` is 1 and 0 otherwise.
- R10: Each bit of a data read returns 0 for a pin not in simple I/O, the latch bit for a driving pin, and the pad level XOR the inversion bit for an input pin.
- R11: Configuration accesses take effect only while `cfg_sel` is 1. While it is 0, writes are dropped and `cfg_rdata` is 0x00.
- R12: Configuration indices with no register, including 0xB5 to 0xB7 and 0xC5 to 0xC7, read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | GPIO device space selected on the configuration port |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| pad_in | input | 64 | Sensed pad levels |
| pad_oe | output | 64 | Pad driver enables |
| pad_out | output | 64 | Pad drive values |

## Verification
The assertions check five things on every cycle:
- pad drivers are quiet when reset releases;
- a pad in a selectable bank never drives while its select bit is 0;
- the three fixed banks' drivers follow their output enables exactly;
- `pad_out` holds still unless a write strobe arrived;
- the configuration port stays silent and keeps its state while deselected, and no data is returned while the base has been zero for two cycles.

Only the bench scenarios can show the following:
- the per-bit read mix of latch, inverted pad level and zero;
- the window edges and the address past 0xFFFF;
- the one-clock lag of the decoder after a base change;
- that unimplemented indices read zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Address decoder states
    typedef enum logic {
        DEC_OFF = 1'b0,
        DEC_ON  = 1'b1
    } dec_state_e;

    // Width of the relocatable data-port base
    localparam int BASE_W = 16;

    // Configuration index map inside the GPIO device space
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] IDX_BASE_LO = 8'h63;
    localparam logic [7:0] IDX_INV0    = 8'hB0;
    localparam logic [7:0] IDX_SEL0    = 8'hC0;
    localparam logic [7:0] IDX_OE0     = 8'hC8;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int NUM_PROG   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_sel,
    input  logic                           cfg_wr,
    input  logic [7:0]                     cfg_idx,
    input  logic [GROUP_W-1:0]             cfg_wdata,
    output logic [GROUP_W-1:0]             cfg_rdata,
    output logic [NUM_PROG*GROUP_W-1:0]    sel_bits,
    output logic [NUM_PROG*GROUP_W-1:0]    inv_bits,
    output logic [NUM_GROUPS*GROUP_W-1:0]  oe_bits,
    output logic [BASE_W-1:0]              base
);

    logic                wr_ok;
    logic [GROUP_W-1:0]  oe_q  [NUM_GROUPS];
    logic [GROUP_W-1:0]  sel_q [NUM_PROG];
    logic [GROUP_W-1:0]  inv_q [NUM_PROG];
    logic [BASE_W-1:0]   base_q;

    assign wr_ok = cfg_sel & cfg_wr;

    // Output-enable register per bank
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe
        localparam logic [7:0] MY_IDX = IDX_OE0 + 8'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                oe_q[g] <= '0;
            else if (wr_ok && cfg_idx == MY_IDX)
                oe_q[g] <= cfg_wdata;
        end
        assign oe_bits[g*GROUP_W +: GROUP_W] = oe_q[g];
    end

    // Select and inversion registers, only for the programmable banks
    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
        localparam logic [7:0] SEL_IDX = IDX_SEL0 + 8'(g);
        localparam logic [7:0] INV_IDX = IDX_INV0 + 8'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[g] <= '0;
                inv_q[g] <= '0;
            end else if (wr_ok) begin
                if (cfg_idx == SEL_IDX) sel_q[g] <= cfg_wdata;
                if (cfg_idx == INV_IDX) inv_q[g] <= cfg_wdata;
            end
        end
        assign sel_bits[g*GROUP_W +: GROUP_W] = sel_q[g];
        assign inv_bits[g*GROUP_W +: GROUP_W] = inv_q[g];
    end

    // Base address, written one byte at a time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_ok && cfg_idx == IDX_BASE_HI)
            base_q[BASE_W-1:8] <= cfg_wdata[7:0];
        else if (wr_ok && cfg_idx == IDX_BASE_LO)
            base_q[7:0] <= cfg_wdata[7:0];
    end
    assign base = base_q;

    // Readback mux; unknown indices and a deselected port return zero
    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel) begin
            if (cfg_idx == IDX_BASE_HI) cfg_rdata = GROUP_W'(base_q[BASE_W-1:8]);
            if (cfg_idx == IDX_BASE_LO) cfg_rdata = GROUP_W'(base_q[7:0]);
            for (int g = 0; g < NUM_GROUPS; g++)
                if (cfg_idx == IDX_OE0 + 8'(g)) cfg_rdata = oe_q[g];
            for (int g = 0; g < NUM_PROG; g++) begin
                if (cfg_idx == IDX_SEL0 + 8'(g)) cfg_rdata = sel_q[g];
                if (cfg_idx == IDX_INV0 + 8'(g)) cfg_rdata = inv_q[g];
            end
        end
    end

endmodule

// File: rtl/gpio_io_decode.sv
module gpio_io_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] io_addr,
    input  logic              io_wr,
    output logic              hit,
    output logic              wr_hit,
    output logic [GRP_W-1:0]  grp
);

    localparam logic [BASE_W-1:0] WIN = BASE_W'(NUM_GROUPS);

    dec_state_e        state_q, state_d;
    logic [BASE_W:0]   offset;
    logic              in_win;
    logic              base_nz;

    // Offset is computed one bit wider so that an address below the base
    // (or a window running past the top) never aliases into the window.
    assign offset  = {1'b0, io_addr} - {1'b0, base};
    assign in_win  = !offset[BASE_W] && (offset[BASE_W-1:0] < WIN);
    assign base_nz = |base;
    assign grp     = offset[GRP_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= DEC_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            DEC_OFF: begin
                if (base_nz) state_d = DEC_ON;   // off_to_on
            end
            DEC_ON: begin
                hit = in_win;
                if (!base_nz) state_d = DEC_OFF; // on_to_off
            end
            default: state_d = DEC_OFF;
        endcase
        wr_hit = hit & io_wr;
    end

endmodule

// File: rtl/gpio_group_slice.sv
module gpio_group_slice #(
    parameter int GROUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [GROUP_W-1:0] wdata,
    input  logic [GROUP_W-1:0] act,
    input  logic [GROUP_W-1:0] inv,
    input  logic [GROUP_W-1:0] oe,
    input  logic [GROUP_W-1:0] pad_in,
    output logic [GROUP_W-1:0] pad_oe,
    output logic [GROUP_W-1:0] pad_out,
    output logic [GROUP_W-1:0] rd_bits
);

    logic [GROUP_W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_en)
            latch_q <= wdata;
    end

    assign pad_oe  = act & oe;
    assign pad_out = latch_q & pad_oe;
    assign rd_bits = act & ((oe & latch_q) | (~oe & (pad_in ^ inv)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int NUM_PROG   = 5,
    localparam int NPINS     = NUM_GROUPS * GROUP_W,
    localparam int NPROG_B   = NUM_PROG * GROUP_W,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sel,
    input  logic               cfg_wr,
    input  logic [7:0]         cfg_idx,
    input  logic [GROUP_W-1:0] cfg_wdata,
    output logic [GROUP_W-1:0] cfg_rdata,
    input  logic [BASE_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic [GROUP_W-1:0] io_wdata,
    output logic [GROUP_W-1:0] io_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out
);

    logic [NPROG_B-1:0]  cfg_sel_bits;
    logic [NPROG_B-1:0]  cfg_inv_bits;
    logic [NPINS-1:0]    cfg_oe_bits;
    logic [BASE_W-1:0]   cfg_base;
    logic                dec_hit;
    logic                dec_wr;
    logic [GRP_W-1:0]    dec_grp;
    logic [GROUP_W-1:0]  grp_rd [NUM_GROUPS];

    gpio_cfg_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W),
        .NUM_PROG   (NUM_PROG)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sel_bits  (cfg_sel_bits),
        .inv_bits  (cfg_inv_bits),
        .oe_bits   (cfg_oe_bits),
        .base      (cfg_base)
    );

    gpio_io_decode #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (cfg_base),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .hit     (dec_hit),
        .wr_hit  (dec_wr),
        .grp     (dec_grp)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic [GROUP_W-1:0] act_g;
        logic [GROUP_W-1:0] inv_g;
        if (g < NUM_PROG) begin : g_sel
            assign act_g = cfg_sel_bits[g*GROUP_W +: GROUP_W];
            assign inv_g = cfg_inv_bits[g*GROUP_W +: GROUP_W];
        end else begin : g_fixed
            assign act_g = '1;
            assign inv_g = '0;
        end

        gpio_group_slice #(
            .GROUP_W (GROUP_W)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (dec_wr && dec_grp == GRP_W'(g)),
            .wdata   (io_wdata),
            .act     (act_g),
            .inv     (inv_g),
            .oe      (cfg_oe_bits[g*GROUP_W +: GROUP_W]),
            .pad_in  (pad_in[g*GROUP_W +: GROUP_W]),
            .pad_oe  (pad_oe[g*GROUP_W +: GROUP_W]),
            .pad_out (pad_out[g*GROUP_W +: GROUP_W]),
            .rd_bits (grp_rd[g])
        );
    end

    assign io_rdata = dec_hit ? grp_rd[dec_grp] : '0;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int NUM_PROG   = 5,
    localparam int NPINS     = NUM_GROUPS * GROUP_W,
    localparam int NPROG_B   = NUM_PROG * GROUP_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_sel,
    input logic               cfg_wr,
    input logic [GROUP_W-1:0] cfg_rdata,
    input logic               io_wr,
    input logic [GROUP_W-1:0] io_rdata,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_out,
    input logic [NPROG_B-1:0] sel_bits,
    input logic [NPINS-1:0]   oe_bits,
    input logic [15:0]        base
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_ZERO_BASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (base == '0 && $past(base) == '0) |-> io_rdata == '0); // R3

    AST_FIXED_BANKS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[NPINS-1:NPROG_B] == oe_bits[NPINS-1:NPROG_B]); // R5

    AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[NPROG_B-1:0] & ~sel_bits) == '0); // R9

    AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && !cfg_wr) |=> $stable(pad_out)); // R8

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |-> cfg_rdata == '0); // R11

    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> ($stable(oe_bits) && $stable(sel_bits) && $stable(base))); // R11

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W),
    .NUM_PROG   (NUM_PROG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .io_wr     (io_wr),
    .io_rdata  (io_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .sel_bits  (cfg_sel_bits),
    .oe_bits   (cfg_oe_bits),
    .base      (cfg_base)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_oe;
    logic [63:0] pad_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0]  m_sel [5];
    logic [7:0]  m_inv [5];
    logic [7:0]  m_oe  [8];
    logic [7:0]  m_lat [8];
    logic [15:0] m_base;

    always #5 clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cfg(input logic [7:0] idx);
        exp_cfg = 8'h00;
        if (idx == 8'h62) exp_cfg = m_base[15:8];
        if (idx == 8'h63) exp_cfg = m_base[7:0];
        for (int g = 0; g < 8; g++) if (idx == 8'hC8 + 8'(g)) exp_cfg = m_oe[g];
        for (int g = 0; g < 5; g++) begin
            if (idx == 8'hC0 + 8'(g)) exp_cfg = m_sel[g];
            if (idx == 8'hB0 + 8'(g)) exp_cfg = m_inv[g];
        end
    endfunction

    function automatic logic [7:0] exp_data(input int g);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            logic a, iv;
            a  = (g < 5) ? m_sel[g][b] : 1'b1;
            iv = (g < 5) ? m_inv[g][b] : 1'b0;
            if (!a)               r[b] = 1'b0;
            else if (m_oe[g][b])  r[b] = m_lat[g][b];
            else                  r[b] = pad_in[g*8+b] ^ iv;
        end
        return r;
    endfunction

    function automatic int exp_grp(input logic [15:0] a);
        int off;
        off = int'(a) - int'(m_base);
        if (m_base == 16'h0 || off < 0 || off > 7) return -1;
        return off;
    endfunction

    task automatic check_pads(input string tag);
        logic [63:0] eoe, eout;
        for (int n = 0; n < 64; n++) begin
            logic a;
            a = (n / 8 < 5) ? m_sel[n/8][n%8] : 1'b1;
            eoe[n]  = a & m_oe[n/8][n%8];
            eout[n] = eoe[n] & m_lat[n/8][n%8];
        end
        chk({tag, " pad_oe"}, pad_oe, eoe);
        chk({tag, " pad_out"}, pad_out, eout);
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx == 8'h62) m_base[15:8] = d;
        if (idx == 8'h63) m_base[7:0] = d;
        for (int g = 0; g < 8; g++) if (idx == 8'hC8 + 8'(g)) m_oe[g] = d;
        for (int g = 0; g < 5; g++) begin
            if (idx == 8'hC0 + 8'(g)) m_sel[g] = d;
            if (idx == 8'hB0 + 8'(g)) m_inv[g] = d;
        end
        #1;
    endtask

    task automatic cfg_check(input logic [7:0] idx, input string tag);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_idx = idx;
        #1 chk(tag, 64'(cfg_rdata), 64'(exp_cfg(idx)));
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        int g;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        g = exp_grp(a);
        if (g >= 0) m_lat[g] = d;
        #1;
    endtask

    task automatic io_check(input logic [15:0] a, input string tag);
        int g;
        @(negedge clk);
        io_addr = a;
        g = exp_grp(a);
        #1 chk(tag, 64'(io_rdata), (g < 0) ? 64'h0 : 64'(exp_data(g)));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int g = 0; g < 5; g++) begin m_sel[g] = '0; m_inv[g] = '0; end
        for (int g = 0; g < 8; g++) begin m_oe[g] = '0; m_lat[g] = '0; end
        m_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check_pads("R1 reset");
        cfg_check(8'h62, "R1 R4 base hi after reset");
        cfg_check(8'hC8, "R1 oe after reset");

        // R3: base zero, data port ignored
        io_check(16'h0000, "R3 read with zero base");
        io_write(16'h0000, 8'hFF);
        io_write(16'h0003, 8'hFF);

        // R11: deselected port
        @(negedge clk);
        cfg_sel = 1'b0; cfg_idx = 8'hC8;
        #1 chk("R11 rdata while deselected", 64'(cfg_rdata), 64'h0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'hFF; cfg_idx = 8'hCF;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_check(8'hCF, "R11 write dropped while deselected");

        // R3: decode lag after the base becomes nonzero, bank 7 as input
        pad_in = 64'h5A00_0000_0000_0000;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_idx = 8'h62; cfg_wdata = 8'h0A;
        @(negedge clk);
        cfg_wr = 1'b0; io_addr = 16'h0A07; m_base = 16'h0A00;
        #1 chk("R3 still off one clock after base set", 64'(io_rdata), 64'h0);
        io_check(16'h0A07, "R3 R10 on after lag, bank 7 input");
        cfg_write(8'h63, 8'h05);
        cfg_check(8'h63, "R4 base lo readback");
        cfg_check(8'h62, "R4 base hi readback");

        // R2: window edges at base 0x0A05
        io_check(16'h0A04, "R2 below window");
        io_check(16'h0A0D, "R2 above window");
        io_check(16'h0A0C, "R2 last bank at base+7");

        // R3: the writes made while off left bank 0 latch at zero
        cfg_write(8'hC0, 8'hFF);
        cfg_write(8'hC8, 8'hFF);
        check_pads("R3 R9 latch untouched by early write");
        io_check(16'h0A05, "R3 bank 0 readback");

        // R8: latch loads while undriven, shows once driven
        io_write(16'h0A06, 8'hA5);
        check_pads("R8 undriven after write");
        cfg_write(8'hC1, 8'hFF);
        cfg_write(8'hC9, 8'h0F);
        check_pads("R8 R9 partial drive");
        pad_in[15:8] = 8'h3C;
        io_check(16'h0A06, "R10 mixed latch and pad bits");

        // R7: inversion on bank 2 inputs
        cfg_write(8'hC2, 8'hFF);
        cfg_write(8'hB2, 8'hF0);
        pad_in[23:16] = 8'h66;
        io_check(16'h0A07, "R7 inverted input read");
        cfg_check(8'hB2, "R7 inversion readback");

        // R5: unselected pins read zero, fixed bank drives without select
        cfg_write(8'hC3, 8'h0F);
        pad_in[31:24] = 8'hFF;
        io_check(16'h0A08, "R5 R10 unselected bits read zero");
        cfg_write(8'hCE, 8'hFF);
        io_write(16'h0A0B, 8'h81);
        check_pads("R5 fixed bank 6 drives");

        // R12: holes in the index map
        cfg_write(8'hC5, 8'hFF);
        cfg_write(8'hB6, 8'hFF);
        cfg_check(8'hC5, "R12 no select reg for bank 5");
        cfg_check(8'hB6, "R12 no inversion reg for bank 6");
        cfg_check(8'h00, "R12 index 0x00");
        io_check(16'h0A0A, "R12 bank 5 unaffected");

        // R2: window running past the top of the address space
        cfg_write(8'h62, 8'hFF);
        cfg_write(8'h63, 8'hFC);
        io_check(16'hFFFF, "R2 bank 3 at top address");
        io_check(16'h0000, "R2 no wrap past top");
        io_write(16'h0000, 8'h00);
        check_pads("R2 wrapped write ignored");

        // R3: base back to zero turns decode off
        cfg_write(8'h62, 8'h00);
        cfg_write(8'h63, 8'h00);
        @(negedge clk);
        io_check(16'h0004, "R3 off after base cleared");

        // Random phase at base 0x0A05
        cfg_write(8'h62, 8'h0A);
        cfg_write(8'h63, 8'h05);
        for (int i = 0; i < 400; i++) begin
            int op, r;
            op = int'($urandom % 4);
            r  = int'($urandom % 18);
            pad_in = {$urandom, $urandom};
            case (op)
                0: begin
                    logic [7:0] idx;
                    if (r < 5)       idx = 8'hB0 + 8'(r);
                    else if (r < 10) idx = 8'hC0 + 8'(r - 5);
                    else             idx = 8'hC8 + 8'(r - 10);
                    cfg_write(idx, 8'($urandom));
                end
                1: io_write(16'h0A05 + 16'($urandom % 10) - 16'd1, 8'($urandom));
                2: io_check(16'h0A05 + 16'($urandom % 10) - 16'd1, "R2 R10 random read");
                default: cfg_check(8'($urandom), "R4 R5 R6 R7 R12 random index");
            endcase
            check_pads("R6 R9 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule